// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides when an external bus master may take over the shared system bus from the processor. The master raises an asynchronous hold request. The arbiter brings that request into the clock domain and waits until the bus is free. The bus is free when no bus cycle is running, or in the clock where the running cycle completes. It then returns an acknowledge and releases the address, data and control drivers in the same clock. The core keeps running during the hold. It is stalled only in the clocks where it asks for a bus cycle that cannot start.

When the request is withdrawn, the acknowledge drops and the drivers turn back on. One turnaround clock follows, in which no bus cycle may start. In the clock after that, a waiting core request is started even if a new hold request is already present. A build parameter sets the polarity of the memory/IO select output. One variant drives high for memory accesses and the other drives high for IO accesses.

Top module: `busgrant_arb`

## Requirements
- R1: While reset is asserted, and right after it, `hold_ack` is 0 and `bus_oe` is 1.
- R2: The hold request passes through a two-flop synchronizer. On an idle bus, `hold_ack` reads 1 after the third rising edge that follows the setting of `hold_req`, and not before.
- R3: While `cyc_active` is 1 and `cyc_done` is 0, no grant is made. With the synchronized request present, `hold_ack` becomes 1 after the edge that ends the clock in which `cyc_done` is 1.
- R4: `bus_oe` is 0 in exactly the clocks where `hold_ack` is 1.
- R5: `hold_ack` stays 1 while the synchronized request stays 1. It reads 0 after the third rising edge that follows the removal of `hold_req`.
- R6: During a hold, `cyc_start` is 0. `core_stall` equals `core_req`, so a core that needs no bus cycle is not stalled.
- R7: In the first clock after the release, `bus_oe` is 1 and `cyc_start` is 0 even with `core_req` at 1.
- R8: In the clock after the turnaround clock, a pending `core_req` starts its cycle (`cyc_start` 1) even if the synchronized request is 1, and no grant is made at that edge.
- R9: In normal ownership, when the bus is free and both the synchronized request and `core_req` are 1, the hold wins: `cyc_start` is 0 and `core_stall` is 1.
- R10: With `IO_HIGH` = 0, `mio_sel` = NOT `core_is_io` (1 means memory). With `IO_HIGH` = 1, `mio_sel` = `core_is_io` (1 means IO).
- R11: In normal ownership with no synchronized request and a free bus, `cyc_start` equals `core_req` and `core_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_req | input | 1 | Asynchronous bus request from an external master |
| cyc_active | input | 1 | A bus cycle is in progress |
| cyc_done | input | 1 | The running bus cycle completes in this clock |
| core_req | input | 1 | The core needs a bus cycle |
| core_is_io | input | 1 | The requested cycle is an IO access |
| hold_ack | output | 1 | Acknowledge to the external master |
| bus_oe | output | 1 | Output enable for address, data and control drivers |
| cyc_start | output | 1 | Permission for the sequencer to begin a bus cycle |
| core_stall | output | 1 | Stall to the core |
| mio_sel | output | 1 | Memory/IO select, polarity set by IO_HIGH |

## Verification
The assertions take for granted that `cyc_done` is raised only while `cyc_active` is 1. They also take for granted that the sequencer starts a new cycle only in a clock where `cyc_start` was given, so `cyc_active` never rises during a hold or a turnaround. The stimulus keeps to both rules. Every vector that sets `cyc_done` also sets `cyc_active`, and a cycle is shown as active only after a clock that granted `cyc_start` or before any hold. Inputs change only on falling edges, so the synchronizer sees clean levels and the latency counts in the requirements are exact.

// File: rtl/busgrant_pkg.sv
package busgrant_pkg;

    typedef enum logic [1:0] {
        ST_OWN    = 2'd0,
        ST_HELD   = 2'd1,
        ST_TURN   = 2'd2,
        ST_RESUME = 2'd3
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
    } arb_regs_t;

endpackage

// File: rtl/busgrant_sync.sv
module busgrant_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[TOP-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[TOP];
endmodule

// File: rtl/busgrant_fsm.sv
module busgrant_fsm
    import busgrant_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_s,
    input  logic cyc_active,
    input  logic cyc_done,
    input  logic core_req,
    output logic hold_ack,
    output logic bus_oe,
    output logic cyc_start,
    output logic core_stall
);
    arb_regs_t r_d, r_q;
    logic      bus_free;
    logic      grant;

    always_comb begin
        r_d       = r_q;
        bus_free  = !cyc_active || cyc_done;
        grant     = 1'b0;
        cyc_start = 1'b0;
        unique case (r_q.st)
            ST_OWN: begin
                grant     = hold_s && bus_free;
                cyc_start = core_req && bus_free && !hold_s;
                if (grant) r_d.st = ST_HELD;
            end
            ST_HELD: begin
                if (!hold_s) r_d.st = ST_TURN;
            end
            ST_TURN: begin
                r_d.st = ST_RESUME;
            end
            ST_RESUME: begin
                cyc_start = core_req && bus_free;
                grant     = hold_s && bus_free && !core_req;
                r_d.st    = grant ? ST_HELD : ST_OWN;
            end
            default: r_d.st = ST_OWN;
        endcase
        core_stall = core_req && !cyc_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_OWN};
        else        r_q <= r_d;
    end

    assign hold_ack = (r_q.st == ST_HELD);
    assign bus_oe   = (r_q.st != ST_HELD);

    p_grant_sampled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_s));

    p_grant_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(!cyc_active || cyc_done));

    p_keep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && hold_s) |=> hold_ack);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_s) |=> (!hold_ack && bus_oe));

    p_stall_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> core_req);

    p_no_start_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !cyc_start);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> (!cyc_start && bus_oe));

    p_resume_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_ack, 2) && !$past(hold_ack) && core_req && !cyc_active)
        |-> cyc_start);
endmodule

// File: rtl/busgrant_arb.sv
module busgrant_arb #(
    parameter int SYNC_STAGES = 2,
    parameter bit IO_HIGH     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic cyc_active,
    input  logic cyc_done,
    input  logic core_req,
    input  logic core_is_io,
    output logic hold_ack,
    output logic bus_oe,
    output logic cyc_start,
    output logic core_stall,
    output logic mio_sel
);
    logic hold_s;

    busgrant_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (hold_req),
        .dout (hold_s)
    );

    busgrant_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_s    (hold_s),
        .cyc_active(cyc_active),
        .cyc_done  (cyc_done),
        .core_req  (core_req),
        .hold_ack  (hold_ack),
        .bus_oe    (bus_oe),
        .cyc_start (cyc_start),
        .core_stall(core_stall)
    );

    generate
        if (IO_HIGH) begin : g_io_high
            assign mio_sel = core_is_io;
        end else begin : g_mem_high
            assign mio_sel = !core_is_io;
        end
    endgenerate

    p_float_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> !bus_oe);
endmodule

// File: tb/busgrant_arb_test.sv
module busgrant_arb_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 1'b0, cyc_active = 1'b0, cyc_done = 1'b0;
    logic core_req = 1'b0, core_is_io = 1'b0;
    logic hold_ack, bus_oe, cyc_start, core_stall, mio_sel;
    logic ack_a, oe_a, st_a, sl_a, mio_alt;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    busgrant_arb uut (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_active(cyc_active),
        .cyc_done(cyc_done), .core_req(core_req), .core_is_io(core_is_io),
        .hold_ack(hold_ack), .bus_oe(bus_oe), .cyc_start(cyc_start),
        .core_stall(core_stall), .mio_sel(mio_sel));

    busgrant_arb #(.IO_HIGH(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_active(cyc_active),
        .cyc_done(cyc_done), .core_req(core_req), .core_is_io(core_is_io),
        .hold_ack(ack_a), .bus_oe(oe_a), .cyc_start(st_a),
        .core_stall(sl_a), .mio_sel(mio_alt));

    // fields: {hold, req, io, act, done, ack, oe, start, stall}
    localparam int NV = 20;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_0_0_0_0_0_1_0_0, // r0  R11 idle
        9'b1_0_1_1_0_0_1_0_0, // r1  cycle running
        9'b1_1_0_1_0_0_1_0_1, // r2  R3 no grant mid cycle
        9'b1_0_1_1_1_1_0_0_0, // r3  R3 grant after done, R4
        9'b1_1_0_0_0_1_0_0_1, // r4  R6 stall during hold
        9'b0_0_1_0_0_1_0_0_0, // r5  R6 no stall without req
        9'b1_0_0_0_0_1_0_0_0, // r6  R5 still held
        9'b1_1_1_0_0_0_1_0_1, // r7  R5 release, R7 turnaround
        9'b1_1_0_0_0_0_1_1_0, // r8  R8 core first despite hold
        9'b1_0_1_1_0_0_1_0_0, // r9  R8 no grant at resume
        9'b0_0_0_1_1_1_0_0_0, // r10 R3 grant at done
        9'b0_0_1_0_0_1_0_0_0, // r11 R5 held
        9'b0_0_0_0_0_0_1_0_0, // r12 R5 released
        9'b0_0_1_0_0_0_1_0_0, // r13 resume, idle
        9'b0_1_0_0_0_0_1_1_0, // r14 R11 start
        9'b1_1_1_0_0_0_1_1_0, // r15 R11 start
        9'b0_1_0_0_0_0_1_0_1, // r16 R9 hold wins
        9'b0_1_1_0_0_1_0_0_1, // r17 R6 held, stalled
        9'b0_0_0_0_0_0_1_0_0, // r18 R7 turnaround
        9'b0_0_1_0_0_0_1_0_0  // r19 resume
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 during reset
        repeat (2) @(posedge clk);
        #2;
        check("R1 ack in reset", hold_ack, 1'b0);
        check("R1 oe in reset", bus_oe, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 ack after reset", hold_ack, 1'b0);
        check("R1 oe after reset", bus_oe, 1'b1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {hold_req, core_req, core_is_io, cyc_active, cyc_done} = VEC[i][8:4];
            @(posedge clk); #2;
            check($sformatf("R4 ack row %0d", i), hold_ack, VEC[i][3]);
            check($sformatf("R4 oe row %0d", i), bus_oe, VEC[i][2]);
            check($sformatf("R7 start row %0d", i), cyc_start, VEC[i][1]);
            check($sformatf("R6 stall row %0d", i), core_stall, VEC[i][0]);
            check($sformatf("R10 mio row %0d", i), mio_sel, ~VEC[i][6]);
        end

        // R10 alternate polarity
        @(negedge clk) core_is_io = 1'b1; #1;
        check("R10 io high variant io", mio_alt, 1'b1);
        @(negedge clk) core_is_io = 1'b0; #1;
        check("R10 io high variant mem", mio_alt, 1'b0);

        // R2 exact synchronizer latency on an idle bus
        @(negedge clk) {hold_req, core_req, cyc_active, cyc_done} = 4'b1000;
        @(posedge clk); #2; check("R2 edge1", hold_ack, 1'b0);
        @(posedge clk); #2; check("R2 edge2", hold_ack, 1'b0);
        @(posedge clk); #2; check("R2 edge3", hold_ack, 1'b1);
        check("R4 float with ack", bus_oe, 1'b0);

        // R1 reset in the middle of a hold
        @(negedge clk) rst_n = 1'b0; #1;
        check("R1 ack mid reset", hold_ack, 1'b0);
        check("R1 oe mid reset", bus_oe, 1'b1);
        @(negedge clk) begin rst_n = 1'b1; hold_req = 1'b0; end
        @(posedge clk); #2;
        check("R11 idle after reset", cyc_start, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule